// File: doc/BRIEF.md
# Prescaled Time Base Counter

This block keeps a 32-bit running timestamp for a bus controller. A 10-bit prescale setting divides the system clock, and each completed prescaler period advances the timestamp by one while the enable bit is set. Clearing the enable bit stops the timestamp and forces both the timestamp and the prescaler phase to zero. Software reaches the block through a small register port with byte enables. It can read or write the whole timestamp word or any one of its four bytes on its own. Every write to the timestamp, even a single byte, restarts the prescaler phase and leaves the prescale setting alone.

Two word addresses are decoded. The timestamp register sits at 0x110. The control register sits at 0x10C, with the enable in bit 0 and the prescale value in bits 17:8. The current timestamp is also driven on a dedicated output for capture logic elsewhere in the controller.

Top module: `tbc_timebase`

## Requirements
- R1: After a synchronous active-low reset, the timestamp, the control register (enable and prescale) and the read data are all zero.
- R2: With prescale 0 and enable set, the timestamp advances by one on every clock.
- R3: With prescale P and enable set, the timestamp advances once every P+1 clocks. After the enable is set, the first advance comes P+1 clocks later. A change of prescale does not itself advance the timestamp.
- R4: While the enable bit (control bit 0) reads 0, the timestamp and the prescaler phase are held at zero, and timestamp writes are dropped. Clearing the enable zeroes the timestamp on the next clock.
- R5: A full-word write to address 0x110 (byte enables 4'b1111) loads the written value on the next clock, with no advance in that cycle.
- R6: A write to 0x110 with byte enables updates only the enabled byte lanes (bit 0 of the byte enables is bits 7:0, bit 3 is bits 31:24). The other lanes keep their values and do not advance in that cycle.
- R7: Any timestamp write with at least one byte enable restarts the prescaler phase, so the next advance comes P+1 clocks after the write.
- R8: A timestamp write leaves the control register unchanged.
- R9: The timestamp wraps from 0xFFFFFFFF to 0 with no other effect.
- R10: A read returns data one clock after the request. Address 0x110 returns the timestamp and 0x10C returns the control register. Byte lanes whose enable is 0 read as zero, unmapped addresses read as zero, and the read data is zero in any cycle with no read.
- R11: Control writes honour byte enables. A write to lane 0 alone changes the enable and leaves the prescale (bits 17:8) as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_addr | input | 12 | Byte address of the word register |
| bus_be | input | 4 | Byte lane enables for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| time_now | output | 32 | Current timestamp value |

## Verification
A write takes effect on the clock edge that samples it. The timestamp and the control state are therefore checked half a cycle after that edge. Read data arrives one edge after the read strobe and holds the value from before that edge's update. Advances due to the prescaler are counted in edges from the last write or enable: with prescale P, the bench idles P edges and checks that no advance has happened, then idles one more edge and checks that the advance has come. All stimulus and sampling happen on the falling clock edge, so each expected value can be tied to a known number of rising edges.

// File: rtl/tbc_pkg.sv
// Package: shared constants for the prescaled time base counter.
// Assumes a 32-bit register port with byte lanes and word-aligned addresses.
package tbc_pkg;

    localparam int TBC_DATA_W  = 32;
    localparam int TBC_PRE_W   = 10;
    localparam int TBC_ADDR_W  = 12;
    localparam int TBC_EN_BIT  = 0;
    localparam int TBC_PRE_LSB = 8;

    localparam logic [TBC_ADDR_W-1:0] TBC_CNT_ADDR  = 12'h110;
    localparam logic [TBC_ADDR_W-1:0] TBC_CTRL_ADDR = 12'h10C;

endpackage

// File: rtl/tbc_prescaler.sv
// Module: prescaler phase counter.
// It produces a one-cycle tick every (period+1) clocks while en is high.
// A restart request or a low enable returns the phase to zero.
// The comparison uses >=, so lowering the period below the current phase
// ends the current period at once instead of running round the full range.
module tbc_prescaler #(
    parameter int PRE_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             restart,
    input  logic [PRE_W-1:0] period,
    output logic             tick
);

    logic [PRE_W-1:0] phase_q;
    logic             at_end;

    // End of the current period.
    assign at_end = (phase_q >= period);

    // Tick is suppressed while stopped or while the phase restarts.
    assign tick = en && !restart && at_end;

    // Phase register: cleared on reset, on disable or on restart, and wraps at the period end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (!en || restart) begin
            phase_q <= '0;
        end else if (at_end) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    // A restart leaves the phase at zero on the next cycle.
    assert_phase_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (phase_q == '0));

    // A stopped block holds the phase at zero.
    assert_phase_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (phase_q == '0));

    // With a nonzero period, two ticks are never adjacent.
    assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (period != '0)) |=> (!tick || (period == '0)));

endmodule

// File: rtl/tbc_count_core.sv
// Module: byte-lane timestamp register.
// It takes the enable, the prescaler tick and a byte-enabled write.
// Priority: a low enable forces zero, then a write loads the enabled lanes
// (the other lanes hold), then a tick advances the whole word by one.
// Assumes CNT_W is a multiple of 8.
module tbc_count_core #(
    parameter int CNT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en,
    input  logic               tick,
    input  logic               wr,
    input  logic [CNT_W/8-1:0] be,
    input  logic [CNT_W-1:0]   wdata,
    output logic [CNT_W-1:0]   count
);

    localparam int LANES = CNT_W / 8;

    logic [CNT_W-1:0] count_q;
    logic [CNT_W-1:0] count_inc;
    logic [CNT_W-1:0] count_d;

    // Incremented word; the carry crosses lane borders, so it is formed once.
    assign count_inc = count_q + 1'b1;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Next value of one byte lane.
        always_comb begin
            if (!en) begin
                count_d[g*8 +: 8] = 8'h00;
            end else if (wr) begin
                count_d[g*8 +: 8] = be[g] ? wdata[g*8 +: 8] : count_q[g*8 +: 8];
            end else if (tick) begin
                count_d[g*8 +: 8] = count_inc[g*8 +: 8];
            end else begin
                count_d[g*8 +: 8] = count_q[g*8 +: 8];
            end
        end

        // A lane not selected by a write holds its value through that cycle.
        assert_lane_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (en && wr && !be[g]) |=> (count_q[g*8 +: 8] == $past(count_q[g*8 +: 8])));
    end

    // Timestamp register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else begin
            count_q <= count_d;
        end
    end

    assign count = count_q;

    // A disabled block shows zero on the next cycle.
    assert_idle_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (count_q == '0));

    // Without a write the count only holds or steps by one.
    assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !wr) |=> ((count_q == $past(count_q)) || (count_q == $past(count_q) + 1'b1)));

    // All-ones steps to zero.
    assert_wrap_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !wr && tick && (count_q == '1)) |=> (count_q == '0));

endmodule

// File: rtl/tbc_regif.sv
// Module: register port for the time base.
// It holds the control word (enable and prescale), decodes timestamp writes
// and returns registered read data with unselected byte lanes masked to zero.
// Assumes one access per cycle and word-aligned addresses.
module tbc_regif import tbc_pkg::*; #(
    parameter int                  DATA_W    = TBC_DATA_W,
    parameter int                  PRE_W     = TBC_PRE_W,
    parameter int                  ADDR_W    = TBC_ADDR_W,
    parameter int                  EN_BIT    = TBC_EN_BIT,
    parameter int                  PRE_LSB   = TBC_PRE_LSB,
    parameter logic [ADDR_W-1:0]   CNT_ADDR  = TBC_CNT_ADDR,
    parameter logic [ADDR_W-1:0]   CTRL_ADDR = TBC_CTRL_ADDR
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W/8-1:0] bus_be,
    input  logic [DATA_W-1:0]   bus_wdata,
    input  logic [DATA_W-1:0]   count,
    output logic                en,
    output logic [PRE_W-1:0]    period,
    output logic                cnt_wr,
    output logic [DATA_W-1:0]   bus_rdata
);

    localparam int LANES = DATA_W / 8;
    localparam logic [DATA_W-1:0] PRE_MASK  = {{(DATA_W-PRE_W){1'b0}}, {PRE_W{1'b1}}} << PRE_LSB;
    localparam logic [DATA_W-1:0] CTRL_MASK = PRE_MASK | (DATA_W'(1) << EN_BIT);

    logic              cnt_sel;
    logic              ctrl_sel;
    logic              ctrl_wr;
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] ctrl_merge;
    logic [DATA_W-1:0] lane_mask;
    logic [DATA_W-1:0] rd_word;

    // Address decode.
    assign cnt_sel  = (bus_addr == CNT_ADDR);
    assign ctrl_sel = (bus_addr == CTRL_ADDR);
    assign cnt_wr   = bus_wr && cnt_sel && (|bus_be);
    assign ctrl_wr  = bus_wr && ctrl_sel;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Expand each byte enable over its lane.
        assign lane_mask[g*8 +: 8] = {8{bus_be[g]}};
    end

    // Control word after a byte-enabled write; bits with no field stay zero.
    assign ctrl_merge = ((bus_wdata & lane_mask) | (ctrl_q & ~lane_mask)) & CTRL_MASK;

    // Control register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q <= ctrl_merge;
        end
    end

    assign en     = ctrl_q[EN_BIT];
    assign period = ctrl_q[PRE_LSB +: PRE_W];

    // Word selected by the read address.
    always_comb begin
        if (cnt_sel) begin
            rd_word = count;
        end else if (ctrl_sel) begin
            rd_word = ctrl_q;
        end else begin
            rd_word = '0;
        end
    end

    // Read data register: the masked word on a read, zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_word & lane_mask;
        end else begin
            bus_rdata <= '0;
        end
    end

    // Any write that does not target the control word leaves it untouched.
    assert_ctrl_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !ctrl_sel) |=> ($stable(en) && $stable(period)));

    // No read request means zero read data in the next cycle.
    assert_rdata_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0));

    // A read with no byte lanes selected returns zero.
    assert_rdata_lanes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && (bus_be == '0)) |=> (bus_rdata == '0));

endmodule

// File: rtl/tbc_timebase.sv
// Module: top of the prescaled time base counter.
// It connects the register port, the prescaler and the byte-lane timestamp.
// Assumes a single clock domain and a synchronous active-low reset.
module tbc_timebase import tbc_pkg::*; #(
    parameter int                CNT_W     = TBC_DATA_W,
    parameter int                PRE_W     = TBC_PRE_W,
    parameter int                ADDR_W    = TBC_ADDR_W,
    parameter logic [ADDR_W-1:0] CNT_ADDR  = TBC_CNT_ADDR,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = TBC_CTRL_ADDR
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [CNT_W/8-1:0] bus_be,
    input  logic [CNT_W-1:0]   bus_wdata,
    output logic [CNT_W-1:0]   bus_rdata,
    output logic [CNT_W-1:0]   time_now
);

    logic             en;
    logic [PRE_W-1:0] period;
    logic             cnt_wr;
    logic             tick;
    logic [CNT_W-1:0] count;

    tbc_regif #(
        .DATA_W    (CNT_W),
        .PRE_W     (PRE_W),
        .ADDR_W    (ADDR_W),
        .EN_BIT    (TBC_EN_BIT),
        .PRE_LSB   (TBC_PRE_LSB),
        .CNT_ADDR  (CNT_ADDR),
        .CTRL_ADDR (CTRL_ADDR)
    ) u_regif (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .count     (count),
        .en        (en),
        .period    (period),
        .cnt_wr    (cnt_wr),
        .bus_rdata (bus_rdata)
    );

    tbc_prescaler #(
        .PRE_W (PRE_W)
    ) u_prescaler (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .restart (cnt_wr),
        .period  (period),
        .tick    (tick)
    );

    tbc_count_core #(
        .CNT_W (CNT_W)
    ) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (en),
        .tick  (tick),
        .wr    (cnt_wr),
        .be    (bus_be),
        .wdata (bus_wdata),
        .count (count)
    );

    assign time_now = count;

    // Reset leaves the timestamp at zero.
    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> (time_now == '0));

endmodule

// File: tb/tbc_timebase_tb.sv
// Bench for tbc_timebase: a vector table walked by one loop, then directed
// checks for reset, read lanes, control byte writes and dropped writes.
module tbc_timebase_tb;

    localparam logic [11:0] A_CNT  = 12'h110;
    localparam logic [11:0] A_CTRL = 12'h10C;
    localparam int          NVEC   = 21;

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [3:0]  be;
        logic [31:0] data;
        logic [7:0]  idle;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    // Each row: optional write, then idle edges, then expected time_now.
    localparam vec_t VTAB [NVEC] = '{
        '{1'b1, A_CTRL, 4'hF, 32'h0000_0001, 8'd4, 32'h0000_0004, 8'd2},  // R2 every clock
        '{1'b1, A_CNT,  4'hF, 32'h1000_0000, 8'd0, 32'h1000_0000, 8'd5},  // R5 word load
        '{1'b0, A_CNT,  4'h0, 32'h0,         8'd3, 32'h1000_0003, 8'd2},  // R2
        '{1'b1, A_CTRL, 4'hF, 32'h0000_0301, 8'd3, 32'h1000_0004, 8'd3},  // R3 P=3 no step yet
        '{1'b0, A_CNT,  4'h0, 32'h0,         8'd1, 32'h1000_0005, 8'd3},  // R3
        '{1'b0, A_CNT,  4'h0, 32'h0,         8'd4, 32'h1000_0006, 8'd3},  // R3 period of 4
        '{1'b0, A_CNT,  4'h0, 32'h0,         8'd2, 32'h1000_0006, 8'd3},  // R3 mid phase
        '{1'b1, A_CNT,  4'h1, 32'h0000_00AA, 8'd0, 32'h1000_00AA, 8'd6},  // R6 lane 0
        '{1'b0, A_CNT,  4'h0, 32'h0,         8'd3, 32'h1000_00AA, 8'd7},  // R7 phase restarted
        '{1'b0, A_CNT,  4'h0, 32'h0,         8'd1, 32'h1000_00AB, 8'd7},  // R7
        '{1'b1, A_CNT,  4'h8, 32'hFF00_0000, 8'd0, 32'hFF00_00AB, 8'd6},  // R6 lane 3
        '{1'b1, A_CTRL, 4'hF, 32'h0000_0001, 8'd0, 32'hFF00_00AB, 8'd3},  // R3 no step on change
        '{1'b1, A_CNT,  4'hF, 32'hFFFF_FFFE, 8'd0, 32'hFFFF_FFFE, 8'd5},  // R5
        '{1'b0, A_CNT,  4'h0, 32'h0,         8'd1, 32'hFFFF_FFFF, 8'd2},  // R2
        '{1'b0, A_CNT,  4'h0, 32'h0,         8'd1, 32'h0000_0000, 8'd9},  // R9 wrap
        '{1'b0, A_CNT,  4'h0, 32'h0,         8'd1, 32'h0000_0001, 8'd9},  // R9
        '{1'b1, A_CTRL, 4'hF, 32'h0000_0300, 8'd0, 32'h0000_0002, 8'd4},  // R4 last step
        '{1'b0, A_CNT,  4'h0, 32'h0,         8'd1, 32'h0000_0000, 8'd4},  // R4 zeroed
        '{1'b1, A_CNT,  4'hF, 32'h1234_5678, 8'd0, 32'h0000_0000, 8'd4},  // R4 write dropped
        '{1'b1, A_CTRL, 4'hF, 32'h0000_0301, 8'd3, 32'h0000_0000, 8'd3},  // R3 full first period
        '{1'b0, A_CNT,  4'h0, 32'h0,         8'd1, 32'h0000_0001, 8'd3}   // R3
    };

    logic        clk;
    logic        rst_n;
    logic        bus_wr;
    logic        bus_rd;
    logic [11:0] bus_addr;
    logic [3:0]  bus_be;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [31:0] time_now;

    int total;
    int bad;

    tbc_timebase u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_be    (bus_be),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .time_now  (time_now)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %08h expected %08h", req, got, exp);
        end
    endtask

    // All tasks start and end on a falling edge.
    task automatic do_write(input logic [11:0] a, input logic [3:0] be, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = 4'h0; bus_wdata = '0;
    endtask

    task automatic do_read(input logic [11:0] a, input logic [3:0] be, output logic [31:0] v);
        bus_rd = 1'b1; bus_addr = a; bus_be = be;
        @(negedge clk);
        bus_rd = 1'b0; bus_be = 4'h0;
        v = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] rv;
        total = 0; bad = 0;
        rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
        bus_addr = '0; bus_be = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state.
        check("R1 time_now", time_now, 32'h0);
        check("R1 rdata", bus_rdata, 32'h0);
        do_read(A_CTRL, 4'hF, rv);
        check("R1 ctrl", rv, 32'h0);

        for (int i = 0; i < NVEC; i++) begin
            if (VTAB[i].wr) do_write(VTAB[i].addr, VTAB[i].be, VTAB[i].data);
            idle(int'(VTAB[i].idle));
            check($sformatf("R%0d vec %0d", VTAB[i].req, i), time_now, VTAB[i].exp);
        end

        // R11 lane-0 control write clears enable, prescale kept.
        do_write(A_CTRL, 4'h1, 32'h0);
        do_read(A_CTRL, 4'hF, rv);
        check("R11 ctrl after lane write", rv, 32'h0000_0300);
        check("R4 cleared by disable", time_now, 32'h0);

        // R8 counter write leaves control intact (and R4 drops it).
        do_write(A_CNT, 4'hF, 32'hA5A5_A5A5);
        do_read(A_CTRL, 4'hF, rv);
        check("R8 ctrl kept", rv, 32'h0000_0300);
        check("R4 write dropped", time_now, 32'h0);

        // R10 read paths.
        do_write(A_CTRL, 4'h1, 32'h0000_0001);
        do_write(A_CNT, 4'hF, 32'hDEAD_BEEF);
        do_read(A_CNT, 4'hF, rv);
        check("R10 full read", rv, 32'hDEAD_BEEF);
        do_read(A_CNT, 4'h4, rv);
        check("R10 lane read", rv, 32'h00AD_0000);
        do_read(12'h200, 4'hF, rv);
        check("R10 unmapped", rv, 32'h0);
        check("R10 idle rdata", bus_rdata, 32'h0);
        idle(1);
        check("R7 step after restart", time_now, 32'hDEAD_BEF0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule